// File: doc/BRIEF.md
# Buffered flash program sequencer

This block programs a parallel NOR flash array that sits on a 32-bit bus built from two 16-bit devices side by side. Software or an upstream engine pulses `start` with a word-aligned destination byte address and a byte count. The sequencer then drives the whole programming conversation with the flash through a request/acknowledge bus port, pulling the data words one at a time from a valid/ready stream.

The transfer is rounded up to whole 64-byte units. It is cut into pieces that each fit inside one 64-byte window of the array, which is the size of the devices' internal write buffer. For each piece the sequencer asks for the buffer and retries until both devices grant it. It then writes the word count, the data and a confirm command, and polls until both devices report ready. A fault reported by either device abandons the rest of the transfer. Every run ends with a status clear and a return to array-read mode. It finishes with a one-cycle `done` pulse, an `error` flag, a `timeout` flag and an offset that locates a fault.

Top module: `flash_buf_prog`

## Requirements
- R1: The byte count is rounded up to the next multiple of 64 and that many bytes (count/4 words) are programmed; a count of zero programs no word and writes no buffer request.
- R2: The first bus access of every run is a write of 0x00500050 to the start address.
- R3: Each piece holds min(words still to program, (64 − (address mod 64))/4) words, so no piece crosses a 64-byte window.
- R4: The buffer is requested by writing 0x00E800E8, then 0x00700070, then reading status; the three accesses repeat until the read shows bit 7 set in both 16-bit halves (mask 0x00800080).
- R5: After a grant one extra status read is made, then the count word is written, holding (words − 1) in bits 15:0 and again in bits 31:16.
- R6: The data words go to consecutive word addresses starting at the piece's first address, and 0x00D000D0 is then written to the address one word past the last data word.
- R7: After the confirm, status is read until both halves show bit 7. If any bit of mask 0x00300030 is then set, `error` rises and no further piece is started.
- R8: Every run ends with a write of 0x00500050 followed by a write of 0x00FF00FF, and `done` is then high for exactly one cycle.
- R9: On a fault, `err_offset` equals (address of the last confirm write − start address + 1). After a clean run it is zero.
- R10: `in_ready` is high only while a data word is due and no bus access is outstanding. Exactly one stream word is taken per data write, and it is written unchanged.
- R11: Once raised, `bus_req` stays high with address, write enable and write data unchanged until the cycle `bus_ack` is seen.
- R12: In each wait loop, if POLL_MAX status reads in a row show not-ready, the run raises `timeout` and `error` and goes to the closing writes. A ready status on the POLL_MAX-th read lets the run continue normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run (sampled when idle) |
| start_addr | input | AW | Word-aligned destination byte address |
| byte_size | input | SW | Number of bytes to program |
| in_data | input | 32 | Stream data word |
| in_valid | input | 1 | Stream word available |
| in_ready | output | 1 | Stream word taken this cycle |
| bus_req | output | 1 | Flash access request |
| bus_we | output | 1 | Access is a write |
| bus_addr | output | AW | Access byte address |
| bus_wdata | output | 32 | Write data or command |
| bus_ack | input | 1 | Access completed (read data valid) |
| bus_rdata | input | 32 | Read data from flash |
| done | output | 1 | One-cycle end-of-run pulse |
| error | output | 1 | Run aborted on fault or timeout |
| timeout | output | 1 | Run aborted by the poll limit |
| err_offset | output | AW | Fault locator, zero after a clean run |

## Verification
Two pairs of events can land on the same status read. In the first, the read that completes the last piece also carries a fault bit, so finishing the run and aborting it coincide; the bench injects the fault on the final piece and expects `error` with an offset that points at that last confirm. In the second, the buffer grant arrives on exactly the last read the poll limit allows; the bench denies the grant POLL_MAX−1 times and expects a clean run, then POLL_MAX times and expects `timeout`. The device model also reports readiness in only one half on some reads, to show that both halves are required.

// File: rtl/fp_pkg.sv
package fp_pkg;

    typedef enum logic [3:0] {
        ST_IDLE      = 4'd0,
        ST_CLR_INIT  = 4'd1,
        ST_REQ_CMD   = 4'd2,
        ST_REQ_RSR   = 4'd3,
        ST_REQ_RD    = 4'd4,
        ST_GRANT_RD  = 4'd5,
        ST_COUNT     = 4'd6,
        ST_DATA      = 4'd7,
        ST_CONFIRM   = 4'd8,
        ST_POLL      = 4'd9,
        ST_FIN_CLR   = 4'd10,
        ST_FIN_ARRAY = 4'd11
    } fp_state_e;

    localparam logic [31:0] FP_CMD_CLEAR  = 32'h0050_0050;
    localparam logic [31:0] FP_CMD_BUFREQ = 32'h00E8_00E8;
    localparam logic [31:0] FP_CMD_STATUS = 32'h0070_0070;
    localparam logic [31:0] FP_CMD_GO     = 32'h00D0_00D0;
    localparam logic [31:0] FP_CMD_ARRAY  = 32'h00FF_00FF;
    localparam logic [31:0] FP_MASK_RDY   = 32'h0080_0080;
    localparam logic [31:0] FP_MASK_FAIL  = 32'h0030_0030;

endpackage

// File: rtl/fp_size_words.sv
module fp_size_words #(
    parameter int SW        = 16,
    parameter int WIN_BYTES = 64
) (
    input  logic [SW-1:0] size_bytes,
    output logic [SW-2:0] words
);
    localparam int WIN_LG = $clog2(WIN_BYTES);

    logic [SW:0] padded;
    logic [SW:0] blocks;

    // round up to whole windows, then express in 32-bit words
    assign padded = {1'b0, size_bytes} + (SW+1)'(WIN_BYTES - 1);
    assign blocks = padded >> WIN_LG;
    assign words  = (SW-1)'(blocks << (WIN_LG - 2));
endmodule

// File: rtl/fp_chunk_calc.sv
module fp_chunk_calc #(
    parameter int RW        = 15,
    parameter int WIN_BYTES = 64,
    parameter int OW        = $clog2(WIN_BYTES / 4),
    parameter int CW        = $clog2(WIN_BYTES / 4) + 1
) (
    input  logic [OW-1:0] win_off,
    input  logic [RW-1:0] rem_words,
    output logic [CW-1:0] chunk_words
);
    localparam int WW = WIN_BYTES / 4;

    logic [CW-1:0] room;

    // words left before the current window ends
    assign room        = CW'(WW) - CW'(win_off);
    assign chunk_words = (rem_words < RW'(room)) ? CW'(rem_words) : room;
endmodule

// File: rtl/fp_status_eval.sv
module fp_status_eval
    import fp_pkg::*;
(
    input  logic [31:0] rdata,
    output logic        ready,
    output logic        fail
);
    assign ready = (rdata & FP_MASK_RDY) == FP_MASK_RDY;
    assign fail  = |(rdata & FP_MASK_FAIL);
endmodule

// File: rtl/flash_buf_prog.sv
module flash_buf_prog
    import fp_pkg::*;
#(
    parameter int AW        = 32,
    parameter int SW        = 16,
    parameter int POLL_MAX  = 1024,
    parameter int WIN_BYTES = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] start_addr,
    input  logic [SW-1:0] byte_size,
    input  logic [31:0]   in_data,
    input  logic          in_valid,
    output logic          in_ready,
    output logic          bus_req,
    output logic          bus_we,
    output logic [AW-1:0] bus_addr,
    output logic [31:0]   bus_wdata,
    input  logic          bus_ack,
    input  logic [31:0]   bus_rdata,
    output logic          done,
    output logic          error,
    output logic          timeout,
    output logic [AW-1:0] err_offset
);
    localparam int RW    = SW - 1;
    localparam int WW    = WIN_BYTES / 4;
    localparam int OFF_W = $clog2(WW);
    localparam int CW    = OFF_W + 1;
    localparam int PW    = (POLL_MAX > 2) ? $clog2(POLL_MAX) : 1;

    typedef struct packed {
        fp_state_e     st;
        logic          req;
        logic          we;
        logic [31:0]   wdata;
        logic [AW-1:0] cur;
        logic [AW-1:0] base;
        logic [RW-1:0] rem;
        logic [CW-1:0] chunk;
        logic [CW-1:0] left;
        logic [PW-1:0] polls;
        logic          done;
        logic          err;
        logic          tmo;
        logic [AW-1:0] eoff;
    } regs_t;

    regs_t q, d;

    logic [RW-1:0] size_words;
    logic [CW-1:0] chunk_words;
    logic [15:0]   cnt_m1;
    logic          st_ready;
    logic          st_fail;
    logic          adv;
    logic          at_limit;
    logic [AW-1:0] off_now;

    fp_size_words #(.SW(SW), .WIN_BYTES(WIN_BYTES)) u_size (
        .size_bytes (byte_size),
        .words      (size_words)
    );

    fp_chunk_calc #(.RW(RW), .WIN_BYTES(WIN_BYTES), .OW(OFF_W), .CW(CW)) u_chunk (
        .win_off     (q.cur[OFF_W+1:2]),
        .rem_words   (q.rem),
        .chunk_words (chunk_words)
    );

    fp_status_eval u_stat (
        .rdata (bus_rdata),
        .ready (st_ready),
        .fail  (st_fail)
    );

    assign cnt_m1   = 16'(chunk_words) - 16'd1;
    assign at_limit = (q.polls == PW'(POLL_MAX - 1));
    assign off_now  = q.cur - q.base + AW'(1);

    always_comb begin
        d        = q;
        d.done   = 1'b0;
        in_ready = 1'b0;
        adv      = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (start) begin
                    d.cur  = start_addr;
                    d.base = start_addr;
                    d.rem  = size_words;
                    d.err  = 1'b0;
                    d.tmo  = 1'b0;
                    d.eoff = '0;
                    d.st   = ST_CLR_INIT;
                    adv    = 1'b1;
                end
            end
            ST_DATA: begin
                if (!q.req) begin
                    if (in_valid) begin
                        in_ready = 1'b1;
                        d.req    = 1'b1;
                        d.we     = 1'b1;
                        d.wdata  = in_data;
                    end
                end else if (bus_ack) begin
                    d.req  = 1'b0;
                    d.cur  = q.cur + AW'(4);
                    d.left = q.left - CW'(1);
                    if (q.left == CW'(1)) begin
                        d.st = ST_CONFIRM;
                        adv  = 1'b1;
                    end
                end
            end
            default: begin
                if (q.req && bus_ack) begin
                    adv = 1'b1;
                    case (q.st)
                        ST_CLR_INIT: begin
                            d.polls = '0;
                            d.st    = (q.rem == '0) ? ST_FIN_CLR : ST_REQ_CMD;
                        end
                        ST_REQ_CMD: d.st = ST_REQ_RSR;
                        ST_REQ_RSR: d.st = ST_REQ_RD;
                        ST_REQ_RD: begin
                            if (st_ready) begin
                                d.st = ST_GRANT_RD;
                            end else if (at_limit) begin
                                d.tmo  = 1'b1;
                                d.err  = 1'b1;
                                d.eoff = off_now;
                                d.st   = ST_FIN_CLR;
                            end else begin
                                d.polls = q.polls + PW'(1);
                                d.st    = ST_REQ_CMD;
                            end
                        end
                        ST_GRANT_RD: begin
                            d.chunk = chunk_words;
                            d.left  = chunk_words;
                            d.st    = ST_COUNT;
                        end
                        ST_COUNT: d.st = ST_DATA;
                        ST_CONFIRM: begin
                            d.polls = '0;
                            d.st    = ST_POLL;
                        end
                        ST_POLL: begin
                            if (st_ready) begin
                                d.polls = '0;
                                if (st_fail) begin
                                    d.err  = 1'b1;
                                    d.eoff = off_now;
                                    d.st   = ST_FIN_CLR;
                                end else begin
                                    d.rem = q.rem - RW'(q.chunk);
                                    d.st  = (q.rem == RW'(q.chunk)) ? ST_FIN_CLR : ST_REQ_CMD;
                                end
                            end else if (at_limit) begin
                                d.tmo  = 1'b1;
                                d.err  = 1'b1;
                                d.eoff = off_now;
                                d.st   = ST_FIN_CLR;
                            end else begin
                                d.polls = q.polls + PW'(1);
                                d.st    = ST_POLL;
                            end
                        end
                        ST_FIN_CLR: d.st = ST_FIN_ARRAY;
                        ST_FIN_ARRAY: begin
                            d.done = 1'b1;
                            d.st   = ST_IDLE;
                        end
                        default: d.st = ST_IDLE;
                    endcase
                end
            end
        endcase

        // launch the access that belongs to the state being entered
        if (adv) begin
            d.req   = 1'b1;
            d.we    = 1'b1;
            d.wdata = '0;
            case (d.st)
                ST_CLR_INIT, ST_FIN_CLR:          d.wdata = FP_CMD_CLEAR;
                ST_REQ_CMD:                       d.wdata = FP_CMD_BUFREQ;
                ST_REQ_RSR:                       d.wdata = FP_CMD_STATUS;
                ST_REQ_RD, ST_GRANT_RD, ST_POLL:  d.we    = 1'b0;
                ST_COUNT:                         d.wdata = {cnt_m1, cnt_m1};
                ST_CONFIRM:                       d.wdata = FP_CMD_GO;
                ST_FIN_ARRAY:                     d.wdata = FP_CMD_ARRAY;
                default: begin
                    d.req = 1'b0;
                    d.we  = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign bus_req    = q.req;
    assign bus_we     = q.we;
    assign bus_addr   = q.cur;
    assign bus_wdata  = q.wdata;
    assign done       = q.done;
    assign error      = q.err;
    assign timeout    = q.tmo;
    assign err_offset = q.eoff;
endmodule

// File: rtl/fp_prog_chk.sv
module fp_prog_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic          in_ready,
    input logic [31:0]   in_data,
    input logic          bus_req,
    input logic          bus_we,
    input logic [AW-1:0] bus_addr,
    input logic [31:0]   bus_wdata,
    input logic          bus_ack,
    input logic          done,
    input logic          error,
    input logic          timeout,
    input logic [AW-1:0] err_offset
);
    // R10
    take_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> in_valid);

    // R10
    word_forward_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |=> (bus_req && bus_we && bus_wdata == $past(in_data)));

    // R10
    busy_no_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> !in_ready);

    // R11
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_wdata) && $stable(bus_we)));

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R12
    timeout_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |-> error);

    // R9
    clean_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !error) |-> (err_offset == '0));
endmodule

bind flash_buf_prog fp_prog_chk #(.AW(AW)) u_fp_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_data    (in_data),
    .bus_req    (bus_req),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_ack    (bus_ack),
    .done       (done),
    .error      (error),
    .timeout    (timeout),
    .err_offset (err_offset)
);

// File: tb/flash_buf_prog_test.sv
`timescale 1ns/1ps
module flash_buf_prog_test;
    localparam int AW = 12;
    localparam int SW = 10;
    localparam int PM = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] start_addr = '0;
    logic [SW-1:0] byte_size = '0;
    logic [31:0]   in_data;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic          bus_req, bus_we, bus_ack;
    logic [AW-1:0] bus_addr;
    logic [31:0]   bus_wdata, bus_rdata;
    logic          done, error, timeout;
    logic [AW-1:0] err_offset;

    always #2.5 clk = ~clk;

    flash_buf_prog #(.AW(AW), .SW(SW), .POLL_MAX(PM), .WIN_BYTES(64)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
        .byte_size(byte_size), .in_data(in_data), .in_valid(in_valid),
        .in_ready(in_ready), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack),
        .bus_rdata(bus_rdata), .done(done), .error(error),
        .timeout(timeout), .err_offset(err_offset)
    );

    int checks = 0;
    int errors = 0;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [31:0] pat(input int i);
        return (32'(i) * 32'h0001_0007) ^ 32'hC35A_0000;
    endfunction

    // run configuration, written by the stimulus process only
    int cfg_deny = 0;
    int cfg_lat = 0;
    int cfg_fail = 0;
    bit cfg_gaps = 1'b0;
    bit model_clr = 1'b0;

    // stream source
    int sidx = 0;
    int gcnt = 0;
    assign in_data = pat(sidx);
    always @(posedge clk) begin
        if (model_clr) sidx <= 0;
        else if (in_valid && in_ready) sidx <= sidx + 1;
    end
    always @(negedge clk) begin
        gcnt <= gcnt + 1;
        in_valid <= !(cfg_gaps && (gcnt % 3 == 1));
    end

    // flash device model
    localparam int P_IDLE = 0, P_REQ = 1, P_RETRY = 2, P_GRANT = 3, P_CNT = 4,
                   P_DATA = 5, P_CONF = 6, P_BUSY = 7;
    logic        ack_q = 1'b0;
    logic [31:0] rd_q = '0;
    logic [31:0] mem [0:1023];
    int phase, deny_left, busy_left, n_left, wcnt, chunk_no, e8_cnt, wr_count;
    int m_rem, exp_next;
    int v_r3, v_r5, v_r6, v_r11;
    logic [31:0] first_wd, prev_wd, last_wd;
    logic [AW-1:0] first_wa, cap_a;
    logic [31:0] cap_d;
    int m_words_cfg;

    assign bus_ack   = ack_q;
    assign bus_rdata = rd_q;

    always @(posedge clk) begin
        if (model_clr) begin
            for (int i = 0; i < 1024; i++) mem[i] = '0;
            phase = P_IDLE; deny_left = 0; busy_left = 0; n_left = 0; wcnt = 0;
            chunk_no = 0; e8_cnt = 0; wr_count = 0; m_rem = m_words_cfg; exp_next = 0;
            v_r3 = 0; v_r5 = 0; v_r6 = 0; v_r11 = 0;
            first_wd = '0; prev_wd = '0; last_wd = '0; first_wa = '0;
            ack_q <= 1'b0;
        end else if (ack_q) begin
            ack_q <= 1'b0;
        end else if (bus_req) begin
            if (wcnt == 0) begin cap_a = bus_addr; cap_d = bus_wdata; end
            else if (bus_addr != cap_a || bus_wdata != cap_d) v_r11++;
            if (wcnt < cfg_lat) begin
                wcnt++;
            end else begin
                wcnt = 0;
                ack_q <= 1'b1;
                if (bus_we) begin
                    wr_count++;
                    if (wr_count == 1) begin first_wa = bus_addr; first_wd = bus_wdata; end
                    prev_wd = last_wd; last_wd = bus_wdata;
                    case (phase)
                        P_CNT: begin
                            int room, ex;
                            room = 16 - int'(bus_addr[5:2]);
                            ex = (m_rem < room) ? m_rem : room;
                            if (bus_wdata[31:16] != bus_wdata[15:0]) v_r5++;
                            if (int'(bus_wdata[15:0]) + 1 != ex) v_r3++;
                            n_left = ex; m_rem -= ex; exp_next = int'(bus_addr);
                            phase = P_DATA;
                        end
                        P_DATA: begin
                            if (int'(bus_addr) != exp_next) v_r6++;
                            mem[bus_addr[AW-1:2]] = bus_wdata;
                            exp_next += 4; n_left--;
                            if (n_left == 0) phase = P_CONF;
                        end
                        P_CONF: begin
                            if (bus_wdata != 32'h00D0_00D0 || int'(bus_addr) != exp_next) v_r6++;
                            phase = P_BUSY; busy_left = 2; chunk_no++;
                        end
                        default: begin
                            if (bus_wdata == 32'h00E8_00E8) begin
                                e8_cnt++;
                                if (phase == P_IDLE) deny_left = cfg_deny;
                                phase = P_REQ;
                            end
                        end
                    endcase
                end else begin
                    case (phase)
                        P_REQ: begin
                            if (deny_left > 0) begin
                                deny_left--; rd_q <= 32'h0000_0080; phase = P_RETRY;
                            end else begin
                                rd_q <= 32'h0080_0080; phase = P_GRANT;
                            end
                        end
                        P_GRANT: begin rd_q <= 32'h0080_0080; phase = P_CNT; end
                        P_BUSY: begin
                            if (busy_left > 0) begin
                                busy_left--; rd_q <= 32'h0080_0000;
                            end else begin
                                rd_q <= 32'h0080_0080 | ((chunk_no == cfg_fail) ? 32'h0020_0000 : 32'h0);
                                phase = P_IDLE;
                            end
                        end
                        default: rd_q <= 32'h0;
                    endcase
                end
            end
        end
    end

    task automatic run_case(input int st, input int sz, input int deny, input int lat,
                            input int failc, input bit gaps);
        int w, a, nch, wt, wfail, c, cyc;
        int exp_chunks, exp_words, exp_off, exp_e8;
        bit exp_err, exp_tmo;
        w = ((sz + 63) / 64) * 16;
        a = st; nch = 0; wt = 0; wfail = 0;
        while (a >= 0 && wt < w) begin
            c = 16 - ((a >> 2) & 15);
            if (c > w - wt) c = w - wt;
            nch++; wt += c; a += 4 * c;
            if (nch == failc) wfail = wt;
        end
        exp_tmo = (deny >= PM);
        exp_err = exp_tmo || (failc >= 1 && failc <= nch);
        exp_chunks = exp_tmo ? 0 : (exp_err ? failc : nch);
        exp_words  = exp_tmo ? 0 : (exp_err ? wfail : w);
        exp_off    = exp_tmo ? 1 : (exp_err ? 4 * wfail + 1 : 0);
        exp_e8     = exp_tmo ? PM : exp_chunks * (deny + 1);

        @(negedge clk);
        cfg_deny = deny; cfg_lat = lat; cfg_fail = failc; cfg_gaps = gaps;
        m_words_cfg = w; model_clr = 1'b1;
        @(negedge clk);
        model_clr = 1'b0;
        start = 1'b1; start_addr = AW'(st); byte_size = SW'(sz);
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        while (!done && cyc < 20000) begin @(negedge clk); cyc++; end
        check(cyc < 20000, "watchdog", cyc, 0);
        if (cyc >= 20000) return;
        // R7 R12
        check(error == exp_err, "R7 error flag", error, exp_err);
        check(timeout == exp_tmo, "R12 timeout flag", timeout, exp_tmo);
        // R9
        check(int'(err_offset) == exp_off, "R9 offset", err_offset, exp_off);
        // R3 R7
        check(chunk_no == exp_chunks, "R3 piece count", chunk_no, exp_chunks);
        check(v_r3 == 0, "R3 count value", v_r3, 0);
        // R4
        check(e8_cnt == exp_e8, "R4 buffer requests", e8_cnt, exp_e8);
        // R5 R6 R11
        check(v_r5 == 0, "R5 count halves", v_r5, 0);
        check(v_r6 == 0, "R6 data or confirm address", v_r6, 0);
        check(v_r11 == 0, "R11 held request", v_r11, 0);
        // R2
        check(first_wa == AW'(st) && first_wd == 32'h0050_0050, "R2 first write", first_wd, 32'h0050_0050);
        // R8
        check(prev_wd == 32'h0050_0050 && last_wd == 32'h00FF_00FF, "R8 closing writes", last_wd, 32'h00FF_00FF);
        // R1 R10
        check(sidx == exp_words, "R10 words taken", sidx, exp_words);
        begin
            int bad;
            bad = 0;
            for (int i = 0; i < exp_words; i++)
                if (mem[(st >> 2) + i] != pat(i)) bad++;
            check(bad == 0, "R1 programmed data", bad, 0);
            check(mem[(st >> 2) + exp_words] == 32'h0, "R1 nothing beyond", mem[(st >> 2) + exp_words], 0);
        end
        @(negedge clk);
        check(done == 1'b0, "R8 done width", done, 0);
        check(in_ready == 1'b0, "R10 idle ready", in_ready, 0);
    endtask

    initial begin
        m_words_cfg = 0;
        repeat (3) @(negedge clk);
        // reset state
        check(done == 0 && error == 0 && timeout == 0, "R8 reset flags", done, 0);
        check(bus_req == 0 && in_ready == 0, "R11 reset bus", bus_req, 0);
        rst_n = 1'b1;
        @(negedge clk);
        begin
            int sizes [5] = '{0, 4, 64, 100, 130};
            for (int off = 0; off < 16; off++)
                for (int s = 0; s < 5; s++)
                    run_case(64 + 4 * off, sizes[s], (off + s) % 3, s % 3, 0, off[0]);
        end
        // R7 fault on first of several pieces, on a middle one, on the last one
        run_case(68, 130, 0, 1, 1, 1'b1);
        run_case(128, 192, 1, 0, 2, 1'b0);
        run_case(100, 100, 0, 2, 3, 1'b1);
        run_case(64, 64, 0, 0, 1, 1'b0);
        // R12 grant on the last allowed read, then no grant at all
        run_case(72, 64, PM - 1, 0, 0, 1'b0);
        run_case(72, 64, PM, 1, 0, 1'b0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule